// File: doc/BRIEF.md
# Comparator Change-Interrupt Controller

This block watches the digital results of three analog comparators and turns changes in them into interrupt flags that software can see. Each result arrives as an asynchronous level and passes through a two-stage synchronizer. Software can switch each channel on or off, read the live results, and receive one combined interrupt request.

Changes are not found by comparing one clock sample with the one before it. Each channel holds a snapshot of its result, and any read or write of the control/status register refreshes that snapshot. While the live result differs from the snapshot on an enabled channel, the channel's flag is set on every cycle, so clearing the flag has no lasting effect until software has touched the control/status register. Software can also set flags itself to raise a simulated interrupt. The request output is gated by a per-channel enable, a peripheral enable and a global enable.

The register bus is simple and single-cycle. Four word addresses are decoded from a 2-bit address. Writes take effect at the clock edge. Read data is combinational from the selected register.

Top module: `cmpchg_irq_ctrl`

## Requirements
- R1: Each `cmp_in` bit reaches the status bits and the change logic through two flip-flops. A level driven before clock edge k appears in the status after edge k+1, and not after edge k alone.
- R2: Address 0 is the control/status register. Bits 2:0 are the read/write enables for channels 2..0, with bit i for channel i. Bits 7:5 read the synchronized results ANDed with the enables: bit 5 is channel 0, bit 6 is channel 1 and bit 7 is channel 2. Bits 4:3 read 0.
- R3: Writes to bits 7:5 and bits 4:3 of address 0 have no effect.
- R4: When an enabled channel's synchronized result differs from its snapshot, its flag is set at the next edge. Flags sit at address 1, bits 3:1, for channels 2..0, so channel i uses bit i+1. A disabled channel never sets its flag.
- R5: While a mismatch persists, a software clear is overridden and the flag reads 1 again.
- R6: Any read or any write of address 0 copies the synchronized results into the snapshots, which ends the mismatch.
- R7: A write to address 1 loads flag bits 3:1. Writing 1 sets a flag and writing 0 clears it. The other bits are ignored and read 0.
- R8: `irq` is 1 exactly when some flag and its matching flag-enable are both 1, the peripheral enable is 1 and the global enable is 1. The flag-enables are at address 2, bits 3:1, laid out like the flags. The global enable is bit 7 and the peripheral enable is bit 6 of address 3. Flags still set when these enables are 0.
- R9: If a mismatch is present in the same cycle as an access to address 0, the snapshot is refreshed and the flag is not set.
- R10: After reset, all enables, flags, snapshots and synchronizer stages are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| cmp_in | input | 3 | Asynchronous comparator results, bit i is channel i |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the two-cycle synchronizer delay and the snapshot refresh after each access to address 0. They also check that a pending mismatch on an enabled channel forces its flag, that disabled channels never raise a flag on their own, that an access to address 0 freezes the flags, and that `irq` never rises without its enables. Some behaviours only the directed scenarios can show, because they depend on ordered sequences of accesses: a cleared flag coming back, a write and a read to address 0 each ending the mismatch, a change hidden by a read that lands on the same cycle, the read-only status bits, and the full enable gating of `irq`.

// File: rtl/cmpchg_pkg.sv
package cmpchg_pkg;
    localparam int NCH = 3;
    localparam int DW  = 8;
    localparam int AW  = 2;

    localparam int EN_LSB   = 0;
    localparam int STAT_LSB = 5;
    localparam int FLAG_LSB = 1;
    localparam int GE_BIT   = 7;
    localparam int PE_BIT   = 6;

    typedef enum logic [AW-1:0] {
        A_CTL  = 2'd0,
        A_FLAG = 2'd1,
        A_FEN  = 2'd2,
        A_GLB  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic ctl_acc;
        logic ctl_wr;
        logic flag_wr;
        logic fen_wr;
        logic glb_wr;
    } bus_dec_t;

    function automatic logic [DW-1:0] place_bits(input logic [NCH-1:0] v, input int lsb);
        logic [DW-1:0] r;
        r = '0;
        for (int i = 0; i < NCH; i++) begin
            r[lsb + i] = v[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/cmpchg_sync.sv
module cmpchg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/cmpchg_regs.sv
module cmpchg_regs
    import cmpchg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_rd,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    input  logic [NCH-1:0] sts,
    input  logic [NCH-1:0] flags,
    output bus_dec_t       dec,
    output logic [NCH-1:0] en,
    output logic [NCH-1:0] fen,
    output logic           pe,
    output logic           ge,
    output logic [DW-1:0]  rdata
);
    reg_addr_e a;
    assign a = reg_addr_e'(reg_addr);

    always_comb begin
        dec         = '0;
        dec.ctl_acc = (reg_rd | reg_wr) && (a == A_CTL);
        dec.ctl_wr  = reg_wr && (a == A_CTL);
        dec.flag_wr = reg_wr && (a == A_FLAG);
        dec.fen_wr  = reg_wr && (a == A_FEN);
        dec.glb_wr  = reg_wr && (a == A_GLB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            fen <= '0;
            pe  <= 1'b0;
            ge  <= 1'b0;
        end else begin
            if (dec.ctl_wr) en  <= reg_wdata[EN_LSB +: NCH];
            if (dec.fen_wr) fen <= reg_wdata[FLAG_LSB +: NCH];
            if (dec.glb_wr) begin
                pe <= reg_wdata[PE_BIT];
                ge <= reg_wdata[GE_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (a)
            A_CTL:  rdata = place_bits(sts, STAT_LSB) | place_bits(en, EN_LSB);
            A_FLAG: rdata = place_bits(flags, FLAG_LSB);
            A_FEN:  rdata = place_bits(fen, FLAG_LSB);
            default: begin
                rdata[GE_BIT] = ge;
                rdata[PE_BIT] = pe;
            end
        endcase
    end
endmodule

// File: rtl/cmpchg_chan.sv
module cmpchg_chan (
    input  logic clk,
    input  logic rst,
    input  logic sync_bit,
    input  logic en_bit,
    input  logic ctl_acc,
    input  logic flag_wr,
    input  logic wr_bit,
    output logic flag,
    output logic snap
);
    logic mism;
    // an access to the status register wins over a pending change
    assign mism = en_bit & (sync_bit ^ snap) & ~ctl_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            snap <= 1'b0;
        end else begin
            if (ctl_acc) snap <= sync_bit;
            if (flag_wr)   flag <= wr_bit | mism;
            else if (mism) flag <= 1'b1;
        end
    end
endmodule

// File: rtl/cmpchg_irq_ctrl.sv
module cmpchg_irq_ctrl
    import cmpchg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_rd,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] cmp_in,
    output logic           irq
);
    logic [NCH-1:0] sync;
    logic [NCH-1:0] en;
    logic [NCH-1:0] fen;
    logic [NCH-1:0] flags;
    logic [NCH-1:0] snap;
    logic [NCH-1:0] sts;
    logic           pe;
    logic           ge;
    bus_dec_t       dec;

    cmpchg_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cmp_in),
        .dout (sync)
    );

    assign sts = sync & en;

    cmpchg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sts       (sts),
        .flags     (flags),
        .dec       (dec),
        .en        (en),
        .fen       (fen),
        .pe        (pe),
        .ge        (ge),
        .rdata     (reg_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cmpchg_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .sync_bit (sync[g]),
            .en_bit   (en[g]),
            .ctl_acc  (dec.ctl_acc),
            .flag_wr  (dec.flag_wr),
            .wr_bit   (reg_wdata[FLAG_LSB + g]),
            .flag     (flags[g]),
            .snap     (snap[g])
        );
    end

    always_comb irq = pe & ge & (|(flags & fen));
endmodule

// File: rtl/cmpchg_irq_chk.sv
module cmpchg_irq_chk
    import cmpchg_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           reg_rd,
    input logic           reg_wr,
    input logic [AW-1:0]  reg_addr,
    input logic [NCH-1:0] cmp_in,
    input logic [NCH-1:0] sync,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] fen,
    input logic [NCH-1:0] flags,
    input logic [NCH-1:0] snap,
    input logic           pe,
    input logic           ge,
    input logic           irq
);
    logic           acc0;
    logic           fwr;
    logic [NCH-1:0] pend;
    logic [1:0]     age;

    assign acc0 = (reg_rd | reg_wr) && (reg_addr == A_CTL);
    assign fwr  = reg_wr && (reg_addr == A_FLAG);
    assign pend = en & (sync ^ snap) & {NCH{~acc0}};

    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_sync_two_stage_R1: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (sync == $past(cmp_in, 2)));

    assert_snapshot_refresh_R6: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && $past(acc0)) |-> (snap == $past(sync)));

    assert_mismatch_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1) |-> ((flags & $past(pend)) == $past(pend)));

    assert_disabled_no_set_R4: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !$past(fwr)) |-> ((flags & ~$past(flags) & ~$past(en)) == '0));

    assert_access_freezes_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && $past(acc0)) |-> (flags == $past(flags)));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pe && ge && (|(flags & fen))));

    assert_reset_clears_R10: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && en == '0 && !irq));
endmodule

bind cmpchg_irq_ctrl cmpchg_irq_chk u_chk (.*);

// File: tb/cmpchg_irq_ctrl_tb.sv
module cmpchg_irq_ctrl_tb;
    import cmpchg_pkg::*;

    logic           clk = 1'b0;
    logic           rst;
    logic           reg_rd;
    logic           reg_wr;
    logic [AW-1:0]  reg_addr;
    logic [DW-1:0]  reg_wdata;
    logic [DW-1:0]  reg_rdata;
    logic [NCH-1:0] cmp_in;
    logic           irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    cmpchg_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmp_in    (cmp_in),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), d);
            chk($sformatf("R10 reset reg %0d", a), d, 8'h00);
        end
        chk("R10 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_status_sync();
        logic [7:0] d;
        bus_write(2'd0, 8'h07);
        cmp_in = 3'b101;
        idle(1);
        bus_read(2'd0, d);
        chk("R1 one edge keeps old status", d, 8'h07);
        bus_read(2'd0, d);
        chk("R1 R2 status after two edges", d, 8'hA7);
        bus_write(2'd0, 8'h05);
        cmp_in = 3'b111;
        idle(3);
        bus_read(2'd0, d);
        chk("R2 disabled channel reads 0", d, 8'hA5);
        bus_read(2'd1, d);
        chk("R4 disabled channel sets no flag", d, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        cmp_in = 3'b000;
        idle(3);
        bus_read(2'd1, d);
        chk("R4 two channels flag", d, 8'h0A);
        bus_write(2'd0, 8'hFD);
        bus_read(2'd0, d);
        chk("R3 status bits not writable", d, 8'h05);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d);
        chk("R6 write to ctl ends mismatch", d, 8'h00);
    endtask

    task automatic t_persist();
        logic [7:0] d;
        cmp_in = 3'b001;
        idle(3);
        bus_read(2'd1, d);
        chk("R4 R8 flag sets with enables off", d, 8'h02);
        chk("R8 no irq with enables off", {7'b0, irq}, 8'h00);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d);
        chk("R5 flag returns after clear", d, 8'h02);
        bus_read(2'd0, d);
        chk("R2 status ch0", d, 8'h25);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d);
        chk("R6 read of ctl ends mismatch", d, 8'h00);
    endtask

    task automatic t_coincide();
        logic [7:0] d;
        cmp_in = 3'b101;
        idle(2);
        bus_read(2'd0, d);
        chk("R9 status seen on access cycle", d, 8'hA5);
        idle(2);
        bus_read(2'd1, d);
        chk("R9 change hidden by access", d, 8'h00);
        cmp_in = 3'b001;
        idle(3);
        bus_read(2'd1, d);
        chk("R4 ch2 change flagged", d, 8'h08);
        bus_read(2'd0, d);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, d);
        chk("R6 cleared after access", d, 8'h00);
    endtask

    task automatic t_sw_flags();
        logic [7:0] d;
        bus_write(2'd1, 8'h0E);
        bus_read(2'd1, d);
        chk("R7 software sets flags", d, 8'h0E);
        bus_write(2'd1, 8'hF1);
        bus_read(2'd1, d);
        chk("R7 software clears flags, other bits ignored", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        bus_write(2'd3, 8'hC0);
        bus_write(2'd2, 8'h08);
        chk("R8 no flag no irq", {7'b0, irq}, 8'h00);
        bus_write(2'd1, 8'h08);
        chk("R8 all enables irq", {7'b0, irq}, 8'h01);
        bus_write(2'd3, 8'h40);
        chk("R8 global off", {7'b0, irq}, 8'h00);
        bus_write(2'd3, 8'h80);
        chk("R8 peripheral off", {7'b0, irq}, 8'h00);
        bus_write(2'd3, 8'hC0);
        chk("R8 both back on", {7'b0, irq}, 8'h01);
        bus_write(2'd2, 8'h04);
        chk("R8 channel enable mismatch", {7'b0, irq}, 8'h00);
        bus_read(2'd3, d);
        chk("R8 global register read", d, 8'hC0);
        bus_read(2'd2, d);
        chk("R8 flag-enable read", d, 8'h04);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        cmp_in    = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_status_sync();
        t_readonly();
        t_persist();
        t_coincide();
        t_sw_flags();
        t_irq();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule